// File: doc/BRIEF.md
# Byte-Wide Serial Port Register Front End

This block puts a small serial transmitter and an external receive queue behind a word-aligned register bus. Each register is one byte wide and sits in its own 32-bit slot, so the word index comes from address bits [4:2] and the two lowest address bits are ignored. Four constant identification bytes come first. A data register follows: a write starts a transmission and a read takes one byte from the receive queue. Next is a combined status and control byte. Last are the two bytes of a divisor that sets the serial bit rate.

The transmit side holds one character. A write to the data register while the line is idle starts an 8N1 frame on `txd`, sent least significant bit first. Each bit lasts four ticks of a prescaler that divides the clock by divisor+1. The receive queue sits outside the block. The block sees its head byte and its empty, full and one-slot-left flags, and it pulses `rxf_pop` when the queue is read. The external receiver reports framing and overrun errors as one-cycle pulses. A single `irq` output merges the receive causes and the transmit cause.

Top module: `uart_regfront`

## Requirements
- R1: After reset, status reads 0xA0 when the queue is empty. `irq` is 0, `txd` is 1, and the divisor reads back RESET_DIV. `txd` stays at 1 whenever the transmitter is idle.
- R2: Word indices 0 to 3 (byte offsets 0, 4, 8, 12) return bytes 0 to 3 of ID_WORD. Writes to these registers are ignored.
- R3: The status byte at offset 20 has this layout: bit7 transmitter idle, bit6 transmit enable, bit5 queue empty, bit4 queue has room for one more, bit3 queue full, bit2 receive enable, bit1 overrun, bit0 framing error. Bits 7, 5, 4 and 3 follow the hardware and ignore writes.
- R4: Status bits 2 and 6 are read/write and reset to 0.
- R5: A pulse on `rx_frame_err` or `rx_overrun` sets bit 0 or bit 1. Writing 0 to a set bit clears it, and writing 1 leaves it unchanged. A pulse in the same cycle as a clearing write wins, so the bit stays set.
- R6: A read of offset 16 returns the queue head and pops it once. When the queue is empty the read returns 0 and does not pop.
- R7: A write to offset 16 while idle sends a start bit (0), the eight data bits LSB first, then a stop bit (1). Each bit lasts 4*(divisor+1) clocks, counted from the accepting edge. Status bit7 is 0 from that edge until 10 bit times later.
- R8: A write to offset 16 while a frame is in flight is dropped. The line returns to 1 after the current frame and sends nothing more.
- R9: The divisor low byte (offset 24) and high byte (offset 28) are read/write.
- R10: `irq` = (receive enable AND (queue not empty OR framing error OR overrun)) OR (transmit enable AND transmitter idle).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_sel | input | 1 | Bus access strobe |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, combinational from address |
| rxf_data | input | 8 | Receive queue head byte |
| rxf_empty | input | 1 | Receive queue empty |
| rxf_full | input | 1 | Receive queue full |
| rxf_one_left | input | 1 | Receive queue has room for exactly one more byte |
| rxf_pop | output | 1 | Pop the receive queue head |
| rx_frame_err | input | 1 | Framing error pulse from the receiver |
| rx_overrun | input | 1 | Overrun pulse from the receiver |
| txd | output | 1 | Serial transmit line |
| irq | output | 1 | Merged interrupt request |

## Verification
The bench builds the block with RESET_DIV=2, so reset can be told apart from a cleared divisor. It uses an ID_WORD whose four bytes all differ, which makes any swap of the ID slots visible. Before the frame test the bench programs a divisor of 1, so a bit lasts 8 clocks. A whole frame, a write that arrives while a frame is in flight, and the idle tail then fit in about a hundred cycles and can be sampled exactly at mid-bit. A four-deep queue model in the bench reaches the full and one-left flags. Random sequences of pushes, pops, error pulses and status writes drive the merged interrupt through all of its terms.

// File: rtl/uart_fe_pkg.sv
package uart_fe_pkg;
   // word index (byte address bits [4:2]) of each register
   localparam int WIDX_ID0  = 0;
   localparam int WIDX_ID1  = 1;
   localparam int WIDX_ID2  = 2;
   localparam int WIDX_ID3  = 3;
   localparam int WIDX_DATA = 4;
   localparam int WIDX_STAT = 5;
   localparam int WIDX_DIVL = 6;
   localparam int WIDX_DIVH = 7;

   // status byte bit positions, decoded by software
   localparam int SB_FERR  = 0;
   localparam int SB_OVF   = 1;
   localparam int SB_RXIE  = 2;
   localparam int SB_FULL  = 3;
   localparam int SB_ONE   = 4;
   localparam int SB_EMPTY = 5;
   localparam int SB_TXIE  = 6;
   localparam int SB_TXE   = 7;

   localparam int FRAME_BITS = 10;

   typedef struct packed {
      logic rx_ie;
      logic tx_ie;
      logic ferr;
      logic ovf;
   } ctl_t;
endpackage

// File: rtl/uart_fe_baud.sv
module uart_fe_baud #(
   parameter int DIV_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             restart,
   input  logic [DIV_W-1:0] divisor,
   output logic             tick
);
   logic [DIV_W-1:0] cnt_q;

   assign tick = (cnt_q == divisor);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       cnt_q <= '0;
      else if (restart) cnt_q <= '0;
      else if (tick)    cnt_q <= '0;
      else              cnt_q <= cnt_q + 1'b1;
   end
endmodule

// File: rtl/uart_fe_tx.sv
module uart_fe_tx import uart_fe_pkg::*; #(
   parameter int DIV_W      = 16,
   parameter int OVERSAMPLE = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic [7:0]       din,
   input  logic [DIV_W-1:0] divisor,
   output logic             txd,
   output logic             idle
);
   localparam int QW = (OVERSAMPLE > 1) ? $clog2(OVERSAMPLE) : 1;
   localparam int BW = $clog2(FRAME_BITS);
   localparam logic [QW-1:0] Q_LAST = QW'(OVERSAMPLE - 1);
   localparam logic [BW-1:0] B_LAST = BW'(FRAME_BITS - 1);

   logic [FRAME_BITS-1:0] frame_q;
   logic [BW-1:0]         bit_q;
   logic [QW-1:0]         qtr_q;
   logic                  busy_q;
   logic                  load_go;
   logic                  tick;

   assign load_go = load & ~busy_q;

   uart_fe_baud #(.DIV_W(DIV_W)) i_baud (
      .clk     (clk),
      .rst_n   (rst_n),
      .restart (load_go | ~busy_q),
      .divisor (divisor),
      .tick    (tick)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         frame_q <= '1;
         bit_q   <= '0;
         qtr_q   <= '0;
         busy_q  <= 1'b0;
      end else if (load_go) begin
         frame_q <= {1'b1, din, 1'b0};
         bit_q   <= '0;
         qtr_q   <= '0;
         busy_q  <= 1'b1;
      end else if (busy_q && tick) begin
         if (qtr_q == Q_LAST) begin
            qtr_q <= '0;
            if (bit_q == B_LAST) begin
               busy_q  <= 1'b0;
               frame_q <= '1;
            end else begin
               bit_q   <= bit_q + 1'b1;
               frame_q <= {1'b1, frame_q[FRAME_BITS-1:1]};
            end
         end else begin
            qtr_q <= qtr_q + 1'b1;
         end
      end
   end

   assign txd  = busy_q ? frame_q[0] : 1'b1;
   assign idle = ~busy_q;
endmodule

// File: rtl/uart_fe_regs.sv
module uart_fe_regs import uart_fe_pkg::*; #(
   parameter int          ADDR_W    = 5,
   parameter int          DIV_W     = 16,
   parameter logic [15:0] RESET_DIV = 16'd26,
   parameter logic [31:0] ID_WORD   = 32'h0000_0000
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_sel,
   input  logic              bus_wr,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [7:0]        bus_wdata,
   output logic [7:0]        bus_rdata,
   input  logic [7:0]        rxf_data,
   input  logic              rxf_empty,
   input  logic              rxf_full,
   input  logic              rxf_one_left,
   output logic              rxf_pop,
   input  logic              rx_frame_err,
   input  logic              rx_overrun,
   input  logic              tx_idle,
   output logic              tx_load,
   output logic [7:0]        tx_byte,
   output logic [DIV_W-1:0]  divisor,
   output ctl_t              ctl,
   output logic              irq
);
   localparam int HI_W = DIV_W - 8;

   logic             hit;
   logic [2:0]       widx;
   logic             acc_wr, acc_rd, wr_stat;
   ctl_t             ctl_q;
   logic [DIV_W-1:0] div_q;
   logic [7:0]       stat_byte, div_hi_byte;

   generate
      if (ADDR_W > 5) begin : g_upper
         assign hit = (bus_addr[ADDR_W-1:5] == '0);
      end else begin : g_flat
         assign hit = 1'b1;
      end
      if (HI_W == 8) begin : g_hi_full
         assign div_hi_byte = div_q[DIV_W-1:8];
      end else begin : g_hi_part
         assign div_hi_byte = {{(8-HI_W){1'b0}}, div_q[DIV_W-1:8]};
      end
   endgenerate

   assign widx    = bus_addr[4:2];
   assign acc_wr  = bus_sel & bus_wr & hit;
   assign acc_rd  = bus_sel & ~bus_wr & hit;
   assign wr_stat = acc_wr && (widx == 3'(WIDX_STAT));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctl_q <= '0;
         div_q <= RESET_DIV[DIV_W-1:0];
      end else begin
         if (wr_stat) begin
            ctl_q.rx_ie <= bus_wdata[SB_RXIE];
            ctl_q.tx_ie <= bus_wdata[SB_TXIE];
         end
         // error flags: only a written 0 clears, a new pulse always sets
         ctl_q.ferr <= rx_frame_err | (ctl_q.ferr & ~(wr_stat & ~bus_wdata[SB_FERR]));
         ctl_q.ovf  <= rx_overrun   | (ctl_q.ovf  & ~(wr_stat & ~bus_wdata[SB_OVF]));
         if (acc_wr && widx == 3'(WIDX_DIVL)) div_q[7:0]       <= bus_wdata;
         if (acc_wr && widx == 3'(WIDX_DIVH)) div_q[DIV_W-1:8] <= bus_wdata[HI_W-1:0];
      end
   end

   always_comb begin
      stat_byte           = '0;
      stat_byte[SB_FERR]  = ctl_q.ferr;
      stat_byte[SB_OVF]   = ctl_q.ovf;
      stat_byte[SB_RXIE]  = ctl_q.rx_ie;
      stat_byte[SB_FULL]  = rxf_full;
      stat_byte[SB_ONE]   = rxf_one_left;
      stat_byte[SB_EMPTY] = rxf_empty;
      stat_byte[SB_TXIE]  = ctl_q.tx_ie;
      stat_byte[SB_TXE]   = tx_idle;
   end

   always_comb begin
      bus_rdata = '0;
      if (hit) begin
         case (widx)
            3'(WIDX_ID0):  bus_rdata = ID_WORD[7:0];
            3'(WIDX_ID1):  bus_rdata = ID_WORD[15:8];
            3'(WIDX_ID2):  bus_rdata = ID_WORD[23:16];
            3'(WIDX_ID3):  bus_rdata = ID_WORD[31:24];
            3'(WIDX_DATA): bus_rdata = rxf_empty ? 8'h00 : rxf_data;
            3'(WIDX_STAT): bus_rdata = stat_byte;
            3'(WIDX_DIVL): bus_rdata = div_q[7:0];
            default:       bus_rdata = div_hi_byte;
         endcase
      end
   end

   assign rxf_pop = acc_rd && (widx == 3'(WIDX_DATA)) && !rxf_empty;
   assign tx_load = acc_wr && (widx == 3'(WIDX_DATA));
   assign tx_byte = bus_wdata;
   assign divisor = div_q;
   assign ctl     = ctl_q;
   assign irq     = (ctl_q.rx_ie & (~rxf_empty | ctl_q.ferr | ctl_q.ovf))
                  | (ctl_q.tx_ie & tx_idle);
endmodule

// File: rtl/uart_regfront.sv
module uart_regfront import uart_fe_pkg::*; #(
   parameter int          ADDR_W     = 5,
   parameter int          DIV_W      = 16,
   parameter int          OVERSAMPLE = 4,
   parameter logic [15:0] RESET_DIV  = 16'd26,
   parameter logic [31:0] ID_WORD    = 32'h0000_0000
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_sel,
   input  logic              bus_wr,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [7:0]        bus_wdata,
   output logic [7:0]        bus_rdata,
   input  logic [7:0]        rxf_data,
   input  logic              rxf_empty,
   input  logic              rxf_full,
   input  logic              rxf_one_left,
   output logic              rxf_pop,
   input  logic              rx_frame_err,
   input  logic              rx_overrun,
   output logic              txd,
   output logic              irq
);
   generate
      if (ADDR_W < 5) begin : g_bad_addr
         $error("uart_regfront: ADDR_W must be at least 5");
      end
      if (DIV_W < 9 || DIV_W > 16) begin : g_bad_div
         $error("uart_regfront: DIV_W must lie in 9..16");
      end
      if (OVERSAMPLE < 2) begin : g_bad_os
         $error("uart_regfront: OVERSAMPLE must be at least 2");
      end
   endgenerate

   logic             tx_idle;
   logic             tx_load;
   logic [7:0]       tx_byte;
   logic [DIV_W-1:0] divisor;
   ctl_t             ctl;
   logic             rx_ie, tx_ie, frame_err;

   uart_fe_regs #(
      .ADDR_W    (ADDR_W),
      .DIV_W     (DIV_W),
      .RESET_DIV (RESET_DIV),
      .ID_WORD   (ID_WORD)
   ) i_regs (
      .clk          (clk),
      .rst_n        (rst_n),
      .bus_sel      (bus_sel),
      .bus_wr       (bus_wr),
      .bus_addr     (bus_addr),
      .bus_wdata    (bus_wdata),
      .bus_rdata    (bus_rdata),
      .rxf_data     (rxf_data),
      .rxf_empty    (rxf_empty),
      .rxf_full     (rxf_full),
      .rxf_one_left (rxf_one_left),
      .rxf_pop      (rxf_pop),
      .rx_frame_err (rx_frame_err),
      .rx_overrun   (rx_overrun),
      .tx_idle      (tx_idle),
      .tx_load      (tx_load),
      .tx_byte      (tx_byte),
      .divisor      (divisor),
      .ctl          (ctl),
      .irq          (irq)
   );

   uart_fe_tx #(
      .DIV_W      (DIV_W),
      .OVERSAMPLE (OVERSAMPLE)
   ) i_tx (
      .clk     (clk),
      .rst_n   (rst_n),
      .load    (tx_load),
      .din     (tx_byte),
      .divisor (divisor),
      .txd     (txd),
      .idle    (tx_idle)
   );

   assign rx_ie     = ctl.rx_ie;
   assign tx_ie     = ctl.tx_ie;
   assign frame_err = ctl.ferr;
endmodule

// File: rtl/uart_regfront_chk.sv
module uart_regfront_chk #(
   parameter int ADDR_W = 5
) (
   input logic              clk,
   input logic              rst_n,
   input logic              bus_sel,
   input logic              bus_wr,
   input logic [ADDR_W-1:0] bus_addr,
   input logic [7:0]        bus_wdata,
   input logic              rxf_empty,
   input logic              rxf_pop,
   input logic              rx_frame_err,
   input logic              txd,
   input logic              irq,
   input logic              tx_idle,
   input logic              rx_ie,
   input logic              tx_ie,
   input logic              frame_err
);
   logic hit, wr_data, wr_stat;
   assign hit     = ((bus_addr >> 5) == '0);
   assign wr_data = bus_sel && bus_wr && hit && (bus_addr[4:2] == 3'd4);
   assign wr_stat = bus_sel && bus_wr && hit && (bus_addr[4:2] == 3'd5);

   // R6
   pop_nonempty_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rxf_pop |-> !rxf_empty);

   // R1
   idle_line_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
      tx_idle |-> txd);

   // R10
   irq_tx_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (tx_ie && tx_idle) |-> irq);

   // R7
   tx_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_data && tx_idle) |=> (!txd && !tx_idle));

   // R5
   ferr_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_stat && !bus_wdata[0] && !rx_frame_err) |=> !frame_err);

   // R4
   rxie_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wr_stat |=> (rx_ie == $past(bus_wdata[2])));
endmodule

bind uart_regfront uart_regfront_chk #(.ADDR_W(ADDR_W)) i_regfront_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .bus_sel      (bus_sel),
   .bus_wr       (bus_wr),
   .bus_addr     (bus_addr),
   .bus_wdata    (bus_wdata),
   .rxf_empty    (rxf_empty),
   .rxf_pop      (rxf_pop),
   .rx_frame_err (rx_frame_err),
   .txd          (txd),
   .irq          (irq),
   .tx_idle      (tx_idle),
   .rx_ie        (rx_ie),
   .tx_ie        (tx_ie),
   .frame_err    (frame_err)
);

// File: tb/test_uart_regfront.sv
`timescale 1ns/1ps
module test_uart_regfront;
   localparam logic [31:0] IDW = 32'hC3_5A_01_7E;
   localparam int B = 8;  // 4*(divisor 1 + 1)

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       bus_sel = 1'b0, bus_wr = 1'b0;
   logic [4:0] bus_addr = '0;
   logic [7:0] bus_wdata = '0;
   logic [7:0] bus_rdata;
   logic [7:0] rxf_data;
   logic       rxf_empty, rxf_full, rxf_one_left, rxf_pop;
   logic       rx_frame_err = 1'b0, rx_overrun = 1'b0;
   logic       txd, irq;

   logic [7:0] fmem [4];
   int         fcnt = 0;
   int         checks = 0, errors = 0;
   logic       m_rxie = 0, m_txie = 0, m_fe = 0, m_ovf = 0;

   always #2.5 clk = ~clk;

   always_comb begin
      rxf_data     = fmem[0];
      rxf_empty    = (fcnt == 0);
      rxf_full     = (fcnt == 4);
      rxf_one_left = (fcnt == 3);
   end

   uart_regfront #(.ADDR_W(5), .DIV_W(16), .OVERSAMPLE(4),
                   .RESET_DIV(16'd2), .ID_WORD(IDW)) i_uart_regfront (
      .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
      .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .rxf_data(rxf_data), .rxf_empty(rxf_empty), .rxf_full(rxf_full),
      .rxf_one_left(rxf_one_left), .rxf_pop(rxf_pop),
      .rx_frame_err(rx_frame_err), .rx_overrun(rx_overrun),
      .txd(txd), .irq(irq));

   function automatic logic [7:0] exp_stat(logic txe);
      return {txe, m_txie, fcnt == 0, fcnt == 3, fcnt == 4, m_rxie, m_ovf, m_fe};
   endfunction

   function automatic logic exp_irq(logic txe);
      return (m_rxie & ((fcnt != 0) | m_fe | m_ovf)) | (m_txie & txe);
   endfunction

   task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual %02h expected %02h", req, act, exp);
      end
   endtask

   task automatic bus_read(input logic [4:0] a, output logic [7:0] d);
      logic popped;
      @(negedge clk);
      bus_sel = 1; bus_wr = 0; bus_addr = a;
      #1 d = bus_rdata; popped = rxf_pop;
      @(posedge clk);
      #0.5;
      bus_sel = 0;
      if (popped) begin
         for (int i = 0; i < 3; i++) fmem[i] = fmem[i+1];
         fcnt--;
      end
   endtask

   task automatic bus_write(input logic [4:0] a, input logic [7:0] d);
      @(negedge clk);
      bus_sel = 1; bus_wr = 1; bus_addr = a; bus_wdata = d;
      @(posedge clk);
      #0.5;
      bus_sel = 0; bus_wr = 0;
   endtask

   task automatic push(input logic [7:0] b);
      fmem[fcnt] = b;
      fcnt++;
   endtask

   task automatic err_pulse(input logic f, input logic o);
      @(negedge clk);
      rx_frame_err = f; rx_overrun = o;
      @(posedge clk);
      #0.5;
      rx_frame_err = 0; rx_overrun = 0;
      m_fe |= f; m_ovf |= o;
   endtask

   initial begin : watchdog
      repeat (150000) @(posedge clk);
      $display("FAIL watchdog: actual hung expected done");
      $display("  Simulation finished: %0d checks, %0d errors", checks + 1, errors + 1);
      $finish;
   end

   initial begin : stim
      logic [7:0] d, w, fr_exp;
      void'($urandom(32'd4711));
      for (int i = 0; i < 4; i++) fmem[i] = 8'h00;
      repeat (3) @(posedge clk);
      #0.5 rst_n = 1;

      // R1 reset state
      bus_read(5'd20, d); chk("R1 status", d, 8'hA0);
      chk("R1 irq", {7'b0, irq}, 8'h00);
      chk("R1 txd", {7'b0, txd}, 8'h01);
      bus_read(5'd24, d); chk("R1 div low", d, 8'h02);
      bus_read(5'd28, d); chk("R1 div high", d, 8'h00);

      // R2 id bytes, writes ignored
      for (int k = 0; k < 4; k++) begin
         bus_write(5'(4*k), 8'hFF);
         bus_read(5'(4*k), d); chk("R2 id", d, IDW[8*k +: 8]);
      end

      // R9 divisor read/write
      bus_write(5'd24, 8'h34); bus_write(5'd28, 8'h12);
      bus_read(5'd24, d); chk("R9 low", d, 8'h34);
      bus_read(5'd28, d); chk("R9 high", d, 8'h12);

      // R6 empty read returns 0 without pop
      bus_read(5'd16, d); chk("R6 empty read", d, 8'h00);

      // R3 read-only bits ignore writes, R4 enables
      push(8'h11); push(8'h22); push(8'h33);
      bus_write(5'd20, 8'hFF); m_rxie = 1; m_txie = 1;
      bus_read(5'd20, d); chk("R3 one-left and R4 enables", d, exp_stat(1'b1));
      push(8'h44);
      bus_read(5'd20, d); chk("R3 full", d, exp_stat(1'b1));
      bus_write(5'd20, 8'h00); m_rxie = 0; m_txie = 0;
      bus_read(5'd20, d); chk("R4 enables cleared", d, exp_stat(1'b1));

      // R5 same-cycle set wins over clear
      @(negedge clk);
      rx_overrun = 1; bus_sel = 1; bus_wr = 1; bus_addr = 5'd20; bus_wdata = 8'h00;
      @(posedge clk); #0.5;
      rx_overrun = 0; bus_sel = 0; bus_wr = 0; m_ovf = 1;
      bus_read(5'd20, d); chk("R5 set beats clear", d, exp_stat(1'b1));
      bus_write(5'd20, 8'h02);
      bus_read(5'd20, d); chk("R5 write 1 keeps", d, exp_stat(1'b1));

      // random mix
      for (int it = 0; it < 400; it++) begin
         case ($urandom % 5)
            0: if (fcnt < 4) push(8'($urandom));
            1: begin
               fr_exp = (fcnt != 0) ? fmem[0] : 8'h00;
               bus_read(5'd16, d); chk("R6 data pop", d, fr_exp);
            end
            2: begin
               w = 8'($urandom);
               bus_write(5'd20, w);
               m_rxie = w[2]; m_txie = w[6];
               m_fe &= w[0]; m_ovf &= w[1];
            end
            3: err_pulse(1'($urandom), 1'($urandom));
            default: begin
               bus_read(5'd20, d); chk("R3 R5 status", d, exp_stat(1'b1));
               #1 chk("R10 irq", {7'b0, irq}, {7'b0, exp_irq(1'b1)});
            end
         endcase
      end

      // drain, clear errors, transmit enable only, divisor 1
      while (fcnt != 0) bus_read(5'd16, d);
      bus_write(5'd20, 8'h40); m_rxie = 0; m_txie = 1; m_fe = 0; m_ovf = 0;
      bus_write(5'd24, 8'h01); bus_write(5'd28, 8'h00);
      #1 chk("R10 irq idle", {7'b0, irq}, 8'h01);

      // R7 frame, R8 dropped write
      bus_write(5'd16, 8'hA5);
      for (int n = 0; n <= 10*B + 2*B; n++) begin
         @(negedge clk);
         if (n == 3) begin
            bus_sel = 1; bus_wr = 1; bus_addr = 5'd16; bus_wdata = 8'h3C;
         end else if (n == 4) begin
            bus_sel = 0; bus_wr = 0; bus_addr = 5'd20;
         end
         #1;
         if (n < 10*B && (n % B) == B/2) begin
            int k;
            k = n / B;
            fr_exp = (k == 0) ? 8'h00 : (k == 9) ? 8'h01 : {7'b0, 8'hA5 >> (k-1)} & 8'h01;
            chk("R7 frame bit", {7'b0, txd}, fr_exp);
         end
         if (n == 6) begin
            chk("R7 busy status", bus_rdata & 8'h80, 8'h00);
            chk("R10 irq busy", {7'b0, irq}, 8'h00);
         end
         if (n == 10*B - 1) chk("R7 busy at end", bus_rdata & 8'h80, 8'h00);
         if (n == 10*B) begin
            chk("R7 idle after frame", bus_rdata & 8'h80, 8'h80);
            chk("R10 irq after frame", {7'b0, irq}, 8'h01);
         end
         if (n >= 10*B) chk("R8 dropped write, line idle", {7'b0, txd}, 8'h01);
      end

      $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule